// File: doc/BRIEF.md
# Dual-Channel DAC Serial Control Logic

This block is the digital front end of a two-channel 16-bit voltage DAC. A serial host writes 24-bit frames through a four-wire port (serial clock, active-low frame enable, data in, data out). Each frame carries a command, a channel selection and a 16-bit code. Each channel holds two registers. The input register receives new codes. The output code register drives the converter. Codes move from the input register to the output code register on an active-low load strobe, on an update command, or at once when the strobe is held low.

An active-low clear input acts on its falling edge. It forces both registers of both channels to a preset code. A select pin chooses that code: zero scale when low, midscale when high. The same preset applies at power-on reset. The serial data output has two uses. It forwards the previous frame, so several devices can be chained. It also returns an input register's contents after a readback-select frame.

Every serial and control pin is synchronised into one system clock, which must run at least four times faster than the serial clock. All edges are detected in that clock domain. The serial clock must idle high when a frame starts. No data stream in this block has a handshake, so there is no back-pressure: a frame is accepted whole or dropped whole.

Top module: `dacs_serial_ctrl`

## Requirements
- R1: Each falling serial-clock edge while the frame enable is low shifts one data bit in, first bit first. The frame word has a command in bits [23:20], a channel mask in [19:16] (bit 16 selects channel A, bit 19 selects channel B, bits 17 and 18 are ignored) and a code in [15:0].
- R2: A frame that ends with fewer than 24 falling edges changes no register. A frame with more than 24 edges uses the last 24 bits received.
- R3: Command 1 writes the code into the input register of each selected channel and marks that channel pending. While the load strobe is high, the output code does not change.
- R4: A falling edge on the load strobe copies the input register to the output code of every pending channel, and both channels update in the same cycle. Channels that are not pending keep their output code.
- R5: While the load strobe is held low and clear is high, command 1 updates the output code of each selected channel directly.
- R6: Command 2 copies the input register to the output code for the selected channels. Command 3 writes the code into both registers of the selected channels.
- R7: Command 4 sets the 2-bit power-down mode of channel A from code bits [1:0] and of channel B from bits [3:2], whatever the mask.
- R8: A falling edge on clear loads both registers of both channels with 0x0000 when the preset select is low, or with 0x8000 when it is high. Load-strobe edges are ignored while clear is low.
- R9: At power-on reset the output codes and input registers take the preset selected by the preset pin, and the power-down modes are 0.
- R10: During a frame, the data output presents the previous complete frame's word, first bit first. The first bit is present from the start of the frame, and the output advances on each rising serial-clock edge after the first falling edge.
- R11: After a complete command-9 frame, the next frame shifts out {8'h00, input register}. The register is channel A's when mask bit 16 was set, otherwise channel B's.
- R12: The data output is 0 when the frame enable is high, after reset, and during the frame that follows a short frame.
- R13: Command 0 and unassigned command codes change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 4x the serial clock |
| rst_n | input | 1 | Asynchronous power-on reset, active low |
| ser_clk | input | 1 | Serial clock, idles high |
| frame_n | input | 1 | Frame enable, active low |
| ser_din | input | 1 | Serial data in |
| load_n | input | 1 | Load strobe, active low |
| clear_n | input | 1 | Clear request, falling-edge active |
| preset_mid | input | 1 | Preset select: 1 for midscale, 0 for zero scale |
| ser_dout | output | 1 | Serial data out (chain or readback) |
| chan_a_code | output | 16 | Channel A output code |
| chan_b_code | output | 16 | Channel B output code |
| chan_a_pd | output | 2 | Channel A power-down mode |
| chan_b_pd | output | 2 | Channel B power-down mode |

## Verification
A corrupted input register or a pending flag stuck in the wrong state is not visible on the code outputs right away. It appears at the next load edge or update command, or in the word a readback returns one frame later. A bit-count or shift error shows on the next frame's data output, either as a word shifted by one position or as zeros where a chained word should appear. The bench therefore compares every output after every operation against a model, and compares the whole data-output word on every frame, so a fault in hidden state shows within one or two operations.

// File: rtl/dacs_pkg.sv
package dacs_pkg;
  localparam int FRAME_W = 24;
  localparam int CODE_W  = 16;
  localparam int NCH     = 2;
  localparam int PD_W    = 2;
  localparam int CMD_W   = 4;

  localparam logic [CMD_W-1:0] CMD_NOP    = 4'd0;
  localparam logic [CMD_W-1:0] CMD_WR_IN  = 4'd1;
  localparam logic [CMD_W-1:0] CMD_UPD    = 4'd2;
  localparam logic [CMD_W-1:0] CMD_WR_UPD = 4'd3;
  localparam logic [CMD_W-1:0] CMD_PWR    = 4'd4;
  localparam logic [CMD_W-1:0] CMD_RDSEL  = 4'd9;

  localparam logic [CODE_W-1:0] ZERO_CODE = '0;
  localparam logic [CODE_W-1:0] MID_CODE  = {1'b1, {(CODE_W-1){1'b0}}};
endpackage

// File: rtl/dacs_sync.sv
module dacs_sync #(
  parameter int W = 1,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q,
  output logic [W-1:0] q_d
);
  logic [W-1:0] stg [STAGES];

  genvar i;
  generate
    for (i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) stg[0] <= RST_VAL;
          else        stg[0] <= d;
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) stg[i] <= RST_VAL;
          else        stg[i] <= stg[i-1];
      end
    end
  endgenerate

  assign q = stg[STAGES-1];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) q_d <= RST_VAL;
    else        q_d <= q;
endmodule

// File: rtl/dacs_shift.sv
module dacs_shift
  import dacs_pkg::*;
#(
  parameter int FW = FRAME_W,
  parameter int CW = CODE_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sclk_rise,
  input  logic          sclk_fall,
  input  logic          cs_fall,
  input  logic          cs_rise,
  input  logic          in_frame,
  input  logic          din,
  input  logic [CW-1:0] rb_a,
  input  logic [CW-1:0] rb_b,
  output logic          frm_vld,
  output logic [FW-1:0] frm_word,
  output logic          bit_full,
  output logic          sdo
);
  localparam int CNT_W = $clog2(FW + 1);
  localparam int PAD_W = FW - CW;
  localparam int SEL_A = CW;

  logic [FW-1:0]    shreg;
  logic [CNT_W-1:0] cnt;
  logic [FW-1:0]    tx_word;
  logic             tx_valid;
  logic [FW-1:0]    out_reg;
  logic [CMD_W-1:0] rx_cmd;

  assign bit_full = (cnt == CNT_W'(FW));
  assign rx_cmd   = shreg[FW-1 -: CMD_W];
  assign sdo      = out_reg[FW-1] & in_frame;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg    <= '0;
      cnt      <= '0;
      tx_word  <= '0;
      tx_valid <= 1'b0;
      out_reg  <= '0;
      frm_vld  <= 1'b0;
      frm_word <= '0;
    end else begin
      frm_vld <= 1'b0;
      if (cs_fall) begin
        cnt     <= '0;
        out_reg <= tx_valid ? tx_word : '0;
      end else if (in_frame) begin
        if (sclk_fall) begin
          shreg <= {shreg[FW-2:0], din};
          if (!bit_full) cnt <= cnt + 1'b1;
        end
        if (sclk_rise && cnt != '0)
          out_reg <= {out_reg[FW-2:0], 1'b0};
      end
      if (cs_rise) begin
        if (bit_full) begin
          frm_vld  <= 1'b1;
          frm_word <= shreg;
          tx_valid <= 1'b1;
          if (rx_cmd == CMD_RDSEL)
            tx_word <= {{PAD_W{1'b0}}, (shreg[SEL_A] ? rb_a : rb_b)};
          else
            tx_word <= shreg;
        end else begin
          tx_valid <= 1'b0;
        end
      end
    end
  end
endmodule

// File: rtl/dacs_regs.sv
module dacs_regs
  import dacs_pkg::*;
#(
  parameter int N  = NCH,
  parameter int CW = CODE_W,
  parameter int PW = PD_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             preset_pin,
  input  logic             preset_s,
  input  logic             frm_vld,
  input  logic [CMD_W-1:0] frm_cmd,
  input  logic [N-1:0]     frm_sel,
  input  logic [CW-1:0]    frm_data,
  input  logic             load_fall,
  input  logic             load_low,
  input  logic             clear_fall,
  input  logic             clear_high,
  output logic [CW-1:0]    in_q  [N],
  output logic [CW-1:0]    dac_q [N],
  output logic [PW-1:0]    pd_q  [N]
);
  logic [CW-1:0] preset_run;
  logic [CW-1:0] preset_por;
  logic          pass_thru;

  assign preset_run = preset_s   ? MID_CODE : ZERO_CODE;
  assign preset_por = preset_pin ? MID_CODE : ZERO_CODE;
  assign pass_thru  = load_low & clear_high;

  genvar ch;
  generate
    for (ch = 0; ch < N; ch++) begin : g_ch
      logic pend;
      logic hit;
      assign hit = frm_vld & frm_sel[ch];

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          in_q[ch]  <= preset_por;
          dac_q[ch] <= preset_por;
          pd_q[ch]  <= '0;
          pend      <= 1'b0;
        end else if (clear_fall) begin
          in_q[ch]  <= preset_run;
          dac_q[ch] <= preset_run;
          pend      <= 1'b0;
        end else begin
          if (load_fall && clear_high && pend) begin
            dac_q[ch] <= in_q[ch];
            pend      <= 1'b0;
          end
          if (hit) begin
            case (frm_cmd)
              CMD_WR_IN: begin
                in_q[ch] <= frm_data;
                if (pass_thru) begin
                  dac_q[ch] <= frm_data;
                  pend      <= 1'b0;
                end else begin
                  pend <= 1'b1;
                end
              end
              CMD_UPD: begin
                dac_q[ch] <= in_q[ch];
                pend      <= 1'b0;
              end
              CMD_WR_UPD: begin
                in_q[ch]  <= frm_data;
                dac_q[ch] <= frm_data;
                pend      <= 1'b0;
              end
              default: ;
            endcase
          end
          if (frm_vld && frm_cmd == CMD_PWR)
            pd_q[ch] <= frm_data[PW*ch +: PW];
        end
      end
    end
  endgenerate
endmodule

// File: rtl/dacs_serial_ctrl.sv
module dacs_serial_ctrl
  import dacs_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ser_clk,
  input  logic              frame_n,
  input  logic              ser_din,
  input  logic              load_n,
  input  logic              clear_n,
  input  logic              preset_mid,
  output logic              ser_dout,
  output logic [CODE_W-1:0] chan_a_code,
  output logic [CODE_W-1:0] chan_b_code,
  output logic [PD_W-1:0]   chan_a_pd,
  output logic [PD_W-1:0]   chan_b_pd
);
  localparam int NSYNC = 6;
  localparam logic [NSYNC-1:0] IDLE_VAL = 6'b011011;
  localparam int MASK_LSB = CODE_W;
  localparam int MASK_MSB = CODE_W + 3;

  logic [NSYNC-1:0] raw, s_q, s_qd;
  assign raw = {preset_mid, clear_n, load_n, ser_din, frame_n, ser_clk};

  dacs_sync #(.W(NSYNC), .STAGES(SYNC_STAGES), .RST_VAL(IDLE_VAL)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(raw), .q(s_q), .q_d(s_qd)
  );

  logic sclk_rise, sclk_fall, cs_fall, cs_rise, cs_high, in_frame;
  logic load_fall, load_low, clear_fall, clear_high, preset_s, din_s;

  assign sclk_rise  =  s_q[0] & ~s_qd[0];
  assign sclk_fall  = ~s_q[0] &  s_qd[0];
  assign cs_high    =  s_q[1];
  assign cs_rise    =  s_q[1] & ~s_qd[1];
  assign cs_fall    = ~s_q[1] &  s_qd[1];
  assign in_frame   = ~s_q[1];
  assign din_s      =  s_q[2];
  assign load_low   = ~s_q[3];
  assign load_fall  = ~s_q[3] &  s_qd[3];
  assign clear_high =  s_q[4];
  assign clear_fall = ~s_q[4] &  s_qd[4];
  assign preset_s   =  s_q[5];

  logic [CODE_W-1:0]  in_q  [NCH];
  logic [CODE_W-1:0]  dac_q [NCH];
  logic [PD_W-1:0]    pd_q  [NCH];
  logic               frm_vld, bit_full;
  logic [FRAME_W-1:0] frm_word;
  logic [CMD_W-1:0]   frm_cmd;
  logic [NCH-1:0]     frm_sel;
  logic [CODE_W-1:0]  frm_data;

  assign frm_cmd  = frm_word[FRAME_W-1 -: CMD_W];
  assign frm_sel  = {frm_word[MASK_MSB], frm_word[MASK_LSB]};
  assign frm_data = frm_word[CODE_W-1:0];

  dacs_shift #(.FW(FRAME_W), .CW(CODE_W)) u_shift (
    .clk(clk), .rst_n(rst_n),
    .sclk_rise(sclk_rise), .sclk_fall(sclk_fall),
    .cs_fall(cs_fall), .cs_rise(cs_rise), .in_frame(in_frame),
    .din(din_s), .rb_a(in_q[0]), .rb_b(in_q[1]),
    .frm_vld(frm_vld), .frm_word(frm_word), .bit_full(bit_full),
    .sdo(ser_dout)
  );

  dacs_regs #(.N(NCH), .CW(CODE_W), .PW(PD_W)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .preset_pin(preset_mid), .preset_s(preset_s),
    .frm_vld(frm_vld), .frm_cmd(frm_cmd), .frm_sel(frm_sel), .frm_data(frm_data),
    .load_fall(load_fall), .load_low(load_low),
    .clear_fall(clear_fall), .clear_high(clear_high),
    .in_q(in_q), .dac_q(dac_q), .pd_q(pd_q)
  );

  assign chan_a_code = dac_q[0];
  assign chan_b_code = dac_q[1];
  assign chan_a_pd   = pd_q[0];
  assign chan_b_pd   = pd_q[1];
endmodule

// File: rtl/dacs_serial_chk.sv
module dacs_serial_chk
  import dacs_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              frm_vld,
  input logic [CMD_W-1:0]  frm_cmd,
  input logic [NCH-1:0]    frm_sel,
  input logic [CODE_W-1:0] frm_data,
  input logic              load_fall,
  input logic              load_low,
  input logic              clear_fall,
  input logic              clear_high,
  input logic              bit_full,
  input logic              cs_high,
  input logic [CODE_W-1:0] dac_a,
  input logic [CODE_W-1:0] dac_b,
  input logic [CODE_W-1:0] in_a,
  input logic [CODE_W-1:0] in_b,
  input logic [PD_W-1:0]   pd_a,
  input logic [PD_W-1:0]   pd_b,
  input logic              sdo
);
  AST_CODES_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(frm_vld) && !$past(load_fall) && !$past(clear_fall)) |-> ($stable(dac_a) && $stable(dac_b))); // R4

  AST_SHORT_NO_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
    frm_vld |-> $past(bit_full)); // R2

  AST_PASS_THROUGH: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(frm_vld) && $past(frm_cmd) == CMD_WR_IN && $past(frm_sel[0]) && $past(load_low)
     && $past(clear_high) && !$past(clear_fall)) |-> (dac_a == $past(frm_data))); // R5

  AST_PD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(frm_vld) |-> ($stable(pd_a) && $stable(pd_b))); // R7

  AST_CLEAR_PRESET: assert property (@(posedge clk) disable iff (!rst_n)
    $past(clear_fall) |-> (dac_a == in_a && dac_b == in_b && dac_a == dac_b
                           && (dac_a == ZERO_CODE || dac_a == MID_CODE))); // R8

  AST_LOAD_IGNORED_IN_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(load_fall) && !$past(clear_high) && !$past(clear_fall) && !$past(frm_vld))
      |-> ($stable(dac_a) && $stable(dac_b))); // R8

  AST_SDO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(cs_high) && cs_high) |-> !sdo); // R12
endmodule

bind dacs_serial_ctrl dacs_serial_chk u_chk (
  .clk(clk), .rst_n(rst_n),
  .frm_vld(frm_vld), .frm_cmd(frm_cmd), .frm_sel(frm_sel), .frm_data(frm_data),
  .load_fall(load_fall), .load_low(load_low),
  .clear_fall(clear_fall), .clear_high(clear_high),
  .bit_full(bit_full), .cs_high(cs_high),
  .dac_a(chan_a_code), .dac_b(chan_b_code),
  .in_a(in_q[0]), .in_b(in_q[1]),
  .pd_a(chan_a_pd), .pd_b(chan_b_pd),
  .sdo(ser_dout)
);

// File: tb/tb_dacs_serial_ctrl.sv
module tb_dacs_serial_ctrl;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ser_clk = 1'b1, frame_n = 1'b1, ser_din = 1'b0;
  logic load_n = 1'b1, clear_n = 1'b1, preset_mid = 1'b1;
  logic ser_dout;
  logic [15:0] chan_a_code, chan_b_code;
  logic [1:0]  chan_a_pd, chan_b_pd;

  dacs_serial_ctrl dut (
    .clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .frame_n(frame_n),
    .ser_din(ser_din), .load_n(load_n), .clear_n(clear_n), .preset_mid(preset_mid),
    .ser_dout(ser_dout), .chan_a_code(chan_a_code), .chan_b_code(chan_b_code),
    .chan_a_pd(chan_a_pd), .chan_b_pd(chan_b_pd)
  );

  always #10 clk = ~clk;

  int total = 0;
  int bad = 0;
  int cyc = 0;

  // model state
  logic [15:0] m_in [2];
  logic [15:0] m_dac [2];
  logic        m_pend [2];
  logic [1:0]  m_pd [2];
  logic [23:0] m_tx;
  logic        m_txv;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 190000) begin
      bad = bad + 1;
      total = total + 1;
      $display("FAIL watchdog: act=%0d exp=done", cyc);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    total = total + 1;
    if (!ok) begin
      bad = bad + 1;
      $display("FAIL %s: act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic check_outs(input string tag);
    check(chan_a_code == m_dac[0], {tag, " codeA"}, 32'(chan_a_code), 32'(m_dac[0]));
    check(chan_b_code == m_dac[1], {tag, " codeB"}, 32'(chan_b_code), 32'(m_dac[1]));
    check(chan_a_pd == m_pd[0], {tag, " pdA"}, 32'(chan_a_pd), 32'(m_pd[0]));
    check(chan_b_pd == m_pd[1], {tag, " pdB"}, 32'(chan_b_pd), 32'(m_pd[1]));
  endtask

  function automatic logic [15:0] preset_val(input logic pm);
    return pm ? 16'h8000 : 16'h0000;
  endfunction

  task automatic model_reset(input logic pm);
    for (int c = 0; c < 2; c++) begin
      m_in[c] = preset_val(pm); m_dac[c] = preset_val(pm);
      m_pend[c] = 1'b0; m_pd[c] = 2'b00;
    end
    m_tx = '0; m_txv = 1'b0;
  endtask

  task automatic model_frame(input logic [31:0] w, input int n);
    logic [23:0] f;
    logic [3:0]  cmd;
    logic [1:0]  sel;
    if (n < 24) begin
      m_txv = 1'b0;
      return;
    end
    f = w[23:0];
    cmd = f[23:20];
    sel = {f[19], f[16]};
    m_txv = 1'b1;
    if (cmd == 4'd9) m_tx = {8'h00, (f[16] ? m_in[0] : m_in[1])};
    else             m_tx = f;
    for (int c = 0; c < 2; c++) begin
      if (sel[c]) begin
        case (cmd)
          4'd1: begin
            m_in[c] = f[15:0];
            if (!load_n && clear_n) begin m_dac[c] = f[15:0]; m_pend[c] = 1'b0; end
            else m_pend[c] = 1'b1;
          end
          4'd2: begin m_dac[c] = m_in[c]; m_pend[c] = 1'b0; end
          4'd3: begin m_in[c] = f[15:0]; m_dac[c] = f[15:0]; m_pend[c] = 1'b0; end
          default: ;
        endcase
      end
      if (cmd == 4'd4) m_pd[c] = f[2*c +: 2];
    end
  endtask

  task automatic model_load_fall();
    if (clear_n)
      for (int c = 0; c < 2; c++)
        if (m_pend[c]) begin m_dac[c] = m_in[c]; m_pend[c] = 1'b0; end
  endtask

  task automatic send(input logic [31:0] w, input int n, output logic [23:0] cap);
    cap = '0;
    frame_n = 1'b0;
    #200;
    for (int i = n - 1; i >= 0; i--) begin
      ser_din = w[i];
      #40;
      if (n - 1 - i < 24) cap[23 - (n - 1 - i)] = ser_dout;
      ser_clk = 1'b0;
      #80;
      ser_clk = 1'b1;
      #80;
    end
    ser_din = 1'b0;
    #40;
    frame_n = 1'b1;
    #400;
  endtask

  task automatic do_frame(input logic [31:0] w, input int n, input string tag, input string sdo_tag);
    logic [23:0] cap, exp;
    int k;
    exp = m_txv ? m_tx : 24'h0;
    send(w, n, cap);
    k = (n < 24) ? n : 24;
    check((cap >> (24 - k)) == (exp >> (24 - k)), sdo_tag, 32'(cap), 32'(exp));
    model_frame(w, n);
    check_outs(tag);
  endtask

  task automatic load_pulse(input string tag);
    load_n = 1'b0; #200;
    model_load_fall();
    load_n = 1'b1; #200;
    check_outs(tag);
  endtask

  task automatic clear_pulse(input logic pm, input bit load_inside, input string tag);
    preset_mid = pm; #100;
    clear_n = 1'b0; #200;
    for (int c = 0; c < 2; c++) begin
      m_in[c] = preset_val(pm); m_dac[c] = preset_val(pm); m_pend[c] = 1'b0;
    end
    if (load_inside) begin
      do_frame({8'h00, 4'h1, 4'h9, 16'h5A5A}, 24, "R8 write during clear", "R10 sdo");
      load_n = 1'b0; #200; load_n = 1'b1; #200;   // R8: ignored, model unchanged
    end
    clear_n = 1'b1; #200;
    check_outs(tag);
  endtask

  function automatic logic [31:0] fw(input logic [3:0] cmd, input logic [3:0] mask, input logic [15:0] d);
    return {8'h00, cmd, mask, d};
  endfunction

  initial begin
    void'($urandom(32'd20240613));
    model_reset(1'b1);
    #100;
    check(chan_a_code == 16'h8000 && chan_b_code == 16'h8000, "R9 reset mid", 32'({chan_a_code, chan_b_code}), 32'h80008000);
    rst_n = 1'b1;
    #200;
    check_outs("R9 after reset");
    check(ser_dout == 1'b0, "R12 idle sdo", 32'(ser_dout), 0);

    // first frame: no valid chained word yet, so data output stays 0 (R12)
    do_frame(fw(4'h1, 4'h1, 16'h1234), 24, "R3 write A held", "R12 sdo first");
    load_pulse("R4 load A only");
    do_frame(fw(4'h1, 4'h9, 16'hBEEF), 24, "R3 write both", "R10 chain");
    load_pulse("R4 load both");
    do_frame(fw(4'h3, 4'h9, 16'h0F0F), 20, "R2 short frame", "R10 chain partial");
    do_frame(fw(4'h0, 4'h0, 16'h0000), 24, "R13 nop", "R12 after short");
    do_frame(fw(4'h4, 4'h0, 16'h000E), 24, "R7 power-down", "R10 chain nop");
    do_frame(fw(4'hB, 4'h9, 16'h7777), 24, "R13 unassigned", "R10 chain pd");
    do_frame(fw(4'h1, 4'h8, 16'h4321), 24, "R3 write B", "R10 chain B");
    do_frame(fw(4'h9, 4'h8, 16'h0000), 24, "R11 readback select", "R10 chain");
    do_frame(fw(4'h0, 4'h0, 16'h0000), 24, "R11 nop", "R11 readback B");
    do_frame(fw(4'h2, 4'h8, 16'h0000), 24, "R6 update B", "R10 chain");
    do_frame(fw(4'h3, 4'h1, 16'hA0A0), 24, "R6 write-update A", "R10 chain");
    do_frame({8'h3F, fw(4'h1, 4'h1, 16'h6666)} , 30, "R2 long frame", "R10 chain");
    do_frame(fw(4'h0, 4'h0, 16'h0000), 24, "R2 nop", "R2 long sdo last 24");
    load_n = 1'b0; #200; model_load_fall(); check_outs("R4 hold low edge");
    do_frame(fw(4'h1, 4'h9, 16'h2468), 24, "R5 pass-through", "R10 chain");
    load_n = 1'b1; #200;
    do_frame(fw(4'h1, 4'h1, 16'h1357), 24, "R3 write A", "R10 chain");
    clear_pulse(1'b0, 1'b1, "R8 clear zero");
    clear_pulse(1'b1, 1'b0, "R8 clear mid");

    for (int it = 0; it < 150; it++) begin
      int op;
      op = $urandom % 12;
      if (op == 0) load_pulse("R4 rand load");
      else if (op == 1) do_frame($urandom, 1 + ($urandom % 23), "R2 rand short", "R10 rand sdo");
      else if (op == 2) clear_pulse(1'($urandom), 1'b0, "R8 rand clear");
      else if (op == 3) begin
        if (load_n) begin load_n = 1'b0; #200; model_load_fall(); end
        else begin load_n = 1'b1; #200; end
        check_outs("R5 rand load level");
      end else begin
        logic [3:0] cmd;
        case ($urandom % 7)
          0: cmd = 4'h0; 1: cmd = 4'h1; 2: cmd = 4'h2; 3: cmd = 4'h3;
          4: cmd = 4'h4; 5: cmd = 4'h9; default: cmd = 4'hD;
        endcase
        do_frame({8'h00, cmd, 4'($urandom), 16'($urandom)}, ($urandom % 8 == 0) ? 27 : 24,
                 "R1 rand frame", "R10 rand sdo");
      end
    end
    load_n = 1'b1;
    #200;

    preset_mid = 1'b0;
    rst_n = 1'b0;
    #100;
    model_reset(1'b0);
    check(chan_a_code == 16'h0 && chan_b_code == 16'h0, "R9 reset zero", 32'({chan_a_code, chan_b_code}), 0);
    rst_n = 1'b1;
    #200;
    check_outs("R9 zero after reset");

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule